// File: doc/BRIEF.md
# Vector Status Register Controller

This block keeps the 64-bit status word of a vector unit and applies the control operations that act on it. It covers the element count, the interruption index, the mask-mode flag, and an in-use bit and a changed bit for each of eight even/odd register pairs. An operation is presented with `valid_i`, an opcode and a 64-bit operand. It takes effect at the next rising clock edge, and its results appear on the registered outputs in the same cycle.

The count and index loads take a signed 32-bit value from the low half of the operand. They clamp it into the range 0 to the section size and report through the condition code how the value compared with the limits. A restore replaces the whole word after checking it for validity. In problem (user) state it rewrites the changed bits from the in-use bits. It also raises a one-cycle clear strobe for every pair that was in use and is no longer in use. A clear operation also strobes the selected pairs, so that the register file next to this block can zero them.

Field layout of the status word: bits 63:49 are reserved and must be zero. Bit 48 is mask mode. Bits 47:32 hold the count and bits 31:16 the index. Bits 15:8 are the in-use bits and bits 7:0 the changed bits. Pair p owns in-use bit 15-p and changed bit 7-p. Opcodes are 0 none, 1 load count, 2 load index, 3 set mask, 4 extract, 5 clear pairs, 6 restore, and 7 is ignored.

Top module: `vsr_ctrl`

## Requirements
- R1: After reset, `vsr_o`, `cc_o`, `result_o`, `clear_pairs_o` and `err_o` are all zero.
- R2: A count load sets `cc_o` from the signed low 32 bits of the operand: 0 for zero, 1 for negative, 2 above SECT_SIZE, 3 otherwise. Only the count and index loads change `cc_o`.
- R3: A count load writes the value clamped to 0..SECT_SIZE into bits 47:32 and leaves the other bits unchanged.
- R4: An index load sets `cc_o` to 0 for zero, 1 for negative, 2 when the value is below the current count, and 3 otherwise.
- R5: An index load writes the value clamped to 0..SECT_SIZE into bits 31:16 and leaves the other bits unchanged.
- R6: Set mask copies operand bit 0 into bit 48 and leaves the other bits unchanged.
- R7: Extract places bits 63:48 on `result_o`, which holds until the next extract, and leaves the status word unchanged.
- R8: Clear pairs zeroes bits 31:16 and, for each operand bit 7-p that is set, clears in-use bit 15-p. It drives `clear_pairs_o[p]` for one cycle.
- R9: A restore whose operand has a nonzero bit in 63:49, a count above SECT_SIZE, or an index at or above SECT_SIZE pulses `err_o`. The status word is left unchanged and no clear strobe is raised.
- R10: A valid restore with `user_mode_i` low loads the operand unchanged.
- R11: A valid restore with `user_mode_i` high loads the operand with bits 7:0 replaced by operand bits 15:8.
- R12: A valid restore drives `clear_pairs_o[p]` for one cycle when in-use bit 15-p was set before and is clear in the new word.
- R13: A cycle with `valid_i` low, or with opcode 7, changes no state and leaves `clear_pairs_o` and `err_o` at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation present this cycle |
| op_i | input | 3 | Opcode |
| operand_i | input | 64 | Operand (signed value in bits 31:0 for loads, pair mask in bits 7:0, full word for restore) |
| user_mode_i | input | 1 | Problem state for restore |
| vsr_o | output | 64 | Status word |
| cc_o | output | 2 | Condition code of the last count or index load |
| result_o | output | 16 | Extracted mode half-word |
| clear_pairs_o | output | 8 | One-cycle clear request per pair |
| err_o | output | 1 | One-cycle restore validity error |

## Verification
A restore in user state that drops in-use bits does three things in one cycle. It rewrites the changed bits, raises a clear strobe, and installs a new count and index. The bench drives such restores after a supervisor restore that set all pairs in use. It checks the word, the strobe and the absence of an error against a behavioural model. A count load issued the cycle before an index load must set the count that the index condition code is compared against. The bench issues such back-to-back pairs, and the same model decides the expected code on every clock.

// File: rtl/vsr_pkg.sv
package vsr_pkg;
  typedef enum logic [2:0] {
    OP_NONE     = 3'd0,
    OP_LOAD_CNT = 3'd1,
    OP_LOAD_IDX = 3'd2,
    OP_SET_MASK = 3'd3,
    OP_EXTRACT  = 3'd4,
    OP_CLEAR    = 3'd5,
    OP_RESTORE  = 3'd6,
    OP_RSVD     = 3'd7
  } vsr_op_e;

  localparam int VSR_W     = 64;
  localparam int FLD_W     = 16;
  localparam int NPAIR     = 8;
  localparam int CHG_LSB   = 0;
  localparam int INUSE_LSB = 8;
  localparam int IDX_LSB   = 16;
  localparam int CNT_LSB   = 32;
  localparam int MODE_LSB  = 48;
  localparam int RESV_LSB  = 49;
endpackage

// File: rtl/vsr_sat.sv
module vsr_sat #(
  parameter int SECT_SIZE = 128,
  parameter bit IS_INDEX  = 1'b0
) (
  input  logic [31:0] value_i,
  input  logic [15:0] count_i,
  output logic [15:0] field_o,
  output logic [1:0]  cc_o
);
  localparam logic signed [32:0] LIMIT = 33'(SECT_SIZE);

  logic signed [32:0] sval;
  logic signed [32:0] cnt_s;
  logic               above;

  assign sval  = {value_i[31], value_i};
  assign cnt_s = {17'b0, count_i};

  generate
    if (IS_INDEX) begin : g_idx
      assign above = sval < cnt_s;
    end else begin : g_cnt
      assign above = sval > LIMIT;
    end
  endgenerate

  always_comb begin
    if (sval == 33'sd0)      cc_o = 2'd0;
    else if (sval < 33'sd0)  cc_o = 2'd1;
    else if (above)          cc_o = 2'd2;
    else                     cc_o = 2'd3;

    if (sval < 33'sd0)       field_o = '0;
    else if (sval > LIMIT)   field_o = 16'(SECT_SIZE);
    else                     field_o = sval[15:0];
  end
endmodule

// File: rtl/vsr_restore_chk.sv
module vsr_restore_chk import vsr_pkg::*; #(
  parameter int SECT_SIZE = 128
) (
  input  logic [VSR_W-1:0] image_i,
  input  logic [NPAIR-1:0] cur_inuse_i,
  input  logic             user_i,
  output logic             bad_o,
  output logic [VSR_W-1:0] image_o,
  output logic [NPAIR-1:0] drop_o
);
  localparam logic [FLD_W-1:0] SECT16 = FLD_W'(SECT_SIZE);

  logic [NPAIR-1:0] new_inuse;
  assign new_inuse = image_i[INUSE_LSB +: NPAIR];

  assign bad_o = (|image_i[VSR_W-1:RESV_LSB])
              || (image_i[CNT_LSB +: FLD_W] >  SECT16)
              || (image_i[IDX_LSB +: FLD_W] >= SECT16);

  always_comb begin
    image_o = image_i;
    if (user_i) image_o[CHG_LSB +: NPAIR] = new_inuse;
  end

  // byte order: bit 7 is pair 0
  assign drop_o = cur_inuse_i & ~new_inuse;
endmodule

// File: rtl/vsr_pair_map.sv
module vsr_pair_map #(
  parameter int NP = 8
) (
  input  logic [NP-1:0] byte_i,
  output logic [NP-1:0] pairs_o
);
  generate
    for (genvar p = 0; p < NP; p++) begin : g_pair
      assign pairs_o[p] = byte_i[NP-1-p];
    end
  endgenerate
endmodule

// File: rtl/vsr_ctrl.sv
module vsr_ctrl import vsr_pkg::*; #(
  parameter int SECT_SIZE = 128
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [2:0]        op_i,
  input  logic [63:0]       operand_i,
  input  logic              user_mode_i,
  output logic [63:0]       vsr_o,
  output logic [1:0]        cc_o,
  output logic [15:0]       result_o,
  output logic [NPAIR-1:0]  clear_pairs_o,
  output logic              err_o
);
  localparam logic [FLD_W-1:0] SECT16 = FLD_W'(SECT_SIZE);

  vsr_op_e          op;
  logic [VSR_W-1:0] vsr_q;
  logic [1:0]       cc_q;
  logic [FLD_W-1:0] res_q;
  logic [NPAIR-1:0] clr_q;
  logic             err_q;

  logic [FLD_W-1:0] sat_field [2];
  logic [1:0]       sat_cc    [2];
  logic [NPAIR-1:0] clr_sel, drop_byte, drop_sel;
  logic [VSR_W-1:0] rst_image;
  logic             rst_bad;

  assign op = vsr_op_e'(op_i);

  // instance 0 handles count, instance 1 handles index
  generate
    for (genvar k = 0; k < 2; k++) begin : g_sat
      vsr_sat #(.SECT_SIZE(SECT_SIZE), .IS_INDEX(k == 1)) u_sat (
        .value_i (operand_i[31:0]),
        .count_i (vsr_q[CNT_LSB +: FLD_W]),
        .field_o (sat_field[k]),
        .cc_o    (sat_cc[k])
      );
    end
  endgenerate

  vsr_restore_chk #(.SECT_SIZE(SECT_SIZE)) u_chk (
    .image_i     (operand_i),
    .cur_inuse_i (vsr_q[INUSE_LSB +: NPAIR]),
    .user_i      (user_mode_i),
    .bad_o       (rst_bad),
    .image_o     (rst_image),
    .drop_o      (drop_byte)
  );

  vsr_pair_map #(.NP(NPAIR)) u_map_clr  (.byte_i(operand_i[NPAIR-1:0]), .pairs_o(clr_sel));
  vsr_pair_map #(.NP(NPAIR)) u_map_drop (.byte_i(drop_byte),            .pairs_o(drop_sel));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vsr_q <= '0;
      cc_q  <= '0;
      res_q <= '0;
      clr_q <= '0;
      err_q <= 1'b0;
    end else begin
      clr_q <= '0;
      err_q <= 1'b0;
      if (valid_i) begin
        case (op)
          OP_LOAD_CNT: begin
            vsr_q[CNT_LSB +: FLD_W] <= sat_field[0];
            cc_q <= sat_cc[0];
          end
          OP_LOAD_IDX: begin
            vsr_q[IDX_LSB +: FLD_W] <= sat_field[1];
            cc_q <= sat_cc[1];
          end
          OP_SET_MASK: vsr_q[MODE_LSB] <= operand_i[0];
          OP_EXTRACT:  res_q <= vsr_q[VSR_W-1:MODE_LSB];
          OP_CLEAR: begin
            vsr_q[IDX_LSB +: FLD_W]   <= '0;
            vsr_q[INUSE_LSB +: NPAIR] <= vsr_q[INUSE_LSB +: NPAIR] & ~operand_i[NPAIR-1:0];
            clr_q <= clr_sel;
          end
          OP_RESTORE: begin
            if (rst_bad) begin
              err_q <= 1'b1;
            end else begin
              vsr_q <= rst_image;
              clr_q <= drop_sel;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign vsr_o         = vsr_q;
  assign cc_o          = cc_q;
  assign result_o      = res_q;
  assign clear_pairs_o = clr_q;
  assign err_o         = err_q;

  p_quiet_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (clear_pairs_o == '0 && !err_o && $stable(vsr_o)));

  p_cnt_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vsr_o[CNT_LSB +: FLD_W] <= SECT16);

  p_idx_range_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vsr_o[IDX_LSB +: FLD_W] <= SECT16);

  p_resv_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vsr_o[VSR_W-1:RESV_LSB] == '0);

  p_err_keep_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op == OP_RESTORE |=> (!err_o || (clear_pairs_o == '0 && $stable(vsr_o))));

  p_clear_idx_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op == OP_CLEAR |=> vsr_o[IDX_LSB +: FLD_W] == '0);

  p_extract_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op == OP_EXTRACT |=> (result_o == $past(vsr_o[VSR_W-1:MODE_LSB]) && $stable(vsr_o)));

  p_user_chg_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op == OP_RESTORE && user_mode_i |=>
      (err_o || vsr_o[CHG_LSB +: NPAIR] == vsr_o[INUSE_LSB +: NPAIR]));
endmodule

// File: tb/vsr_ctrl_test.sv
module vsr_ctrl_test;
  localparam int SECT = 128;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [2:0]  op = 3'd0;
  logic [63:0] operand = '0;
  logic        user = 1'b0;
  logic [63:0] vsr;
  logic [1:0]  cc;
  logic [15:0] res;
  logic [7:0]  clr;
  logic        err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [63:0] m_vsr = '0;
  logic [1:0]  m_cc  = '0;
  logic [15:0] m_res = '0;
  logic [7:0]  m_clr = '0;
  logic        m_err = 1'b0;
  string       m_tag = "R1";
  string       m_cc_tag = "R1";

  always #5 clk = ~clk;

  vsr_ctrl #(.SECT_SIZE(SECT)) uut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .op_i(op), .operand_i(operand),
    .user_mode_i(user), .vsr_o(vsr), .cc_o(cc), .result_o(res),
    .clear_pairs_o(clr), .err_o(err)
  );

  // behavioural reference, updated on each rising edge
  always @(posedge clk) begin
    if (rst_n) begin
      automatic logic [63:0] nv = m_vsr;
      automatic logic [7:0]  nc = '0;
      automatic logic        ne = 1'b0;
      automatic longint      v  = longint'($signed(operand[31:0]));
      automatic longint      clampv = (v < 0) ? 0 : (v > SECT) ? SECT : v;
      automatic string       t = "R13";
      if (valid) begin
        case (op)
          3'd1: begin
            m_cc <= (v == 0) ? 2'd0 : (v < 0) ? 2'd1 : (v > SECT) ? 2'd2 : 2'd3;
            m_cc_tag <= "R2";
            nv[47:32] = 16'(clampv);
            t = "R3";
          end
          3'd2: begin
            m_cc <= (v == 0) ? 2'd0 : (v < 0) ? 2'd1 : (v < longint'(m_vsr[47:32])) ? 2'd2 : 2'd3;
            m_cc_tag <= "R4";
            nv[31:16] = 16'(clampv);
            t = "R5";
          end
          3'd3: begin nv[48] = operand[0]; t = "R6"; end
          3'd4: begin m_res <= m_vsr[63:48]; t = "R7"; end
          3'd5: begin
            nv[31:16] = '0;
            for (int p = 0; p < 8; p++)
              if (operand[7-p]) begin nc[p] = 1'b1; nv[15-p] = 1'b0; end
            t = "R8";
          end
          3'd6: begin
            if (operand[63:49] != 0 || operand[47:32] > SECT || operand[31:16] >= SECT) begin
              ne = 1'b1;
              t = "R9";
            end else begin
              nv = operand;
              if (user) begin nv[7:0] = operand[15:8]; t = "R11"; end
              else t = "R10";
              for (int p = 0; p < 8; p++)
                if (m_vsr[15-p] && !operand[15-p]) begin nc[p] = 1'b1; t = "R12"; end
            end
          end
          default: t = "R13";
        endcase
      end
      m_vsr <= nv;
      m_clr <= nc;
      m_err <= ne;
      m_tag <= t;
    end
  end

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(m_tag,    "vsr",   vsr, m_vsr);
      chk(m_cc_tag, "cc",    64'(cc), 64'(m_cc));
      chk(m_tag,    "clear", 64'(clr), 64'(m_clr));
      chk(m_tag,    "err",   64'(err), 64'(m_err));
      chk(m_tag,    "res",   64'(res), 64'(m_res));
    end
  end

  task automatic issue(input logic [2:0] o, input logic [63:0] d, input logic u);
    @(negedge clk);
    valid = 1'b1; op = o; operand = d; user = u;
  endtask

  task automatic idle();
    @(negedge clk);
    valid = 1'b0; op = 3'd0; operand = '0; user = 1'b0;
  endtask

  function automatic logic [63:0] img(input int c, input int x, input logic m,
                                      input logic [7:0] iu, input logic [7:0] ch);
    return {15'b0, m, 16'(c), 16'(x), iu, ch};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state at the ports
    chk("R1", "vsr",   vsr, 64'd0);
    chk("R1", "cc",    64'(cc), 64'd0);
    chk("R1", "clear", 64'(clr), 64'd0);
    chk("R1", "err",   64'(err), 64'd0);
    chk("R1", "res",   64'(res), 64'd0);
    rst_n = 1'b1;

    // R2/R3 count loads across the comparison bands
    issue(3'd1, 64'd0, 0);
    issue(3'd1, {32'hFFFF_FFFF, 32'hFFFF_FFFB}, 0);
    issue(3'd1, 64'd200, 0);
    issue(3'd1, 64'd128, 0);
    issue(3'd1, 64'd129, 0);
    issue(3'd1, 64'h8000_0000, 0);
    issue(3'd1, {32'hDEAD_BEEF, 32'd50}, 0);
    // R4/R5 index loads, back to back with count
    issue(3'd2, 64'd0, 0);
    issue(3'd2, 64'hFFFF_FFFF, 0);
    issue(3'd2, 64'd10, 0);
    issue(3'd2, 64'd50, 0);
    issue(3'd2, 64'd300, 0);
    issue(3'd1, 64'd5, 0);
    issue(3'd2, 64'd4, 0);
    // R6/R7
    issue(3'd3, 64'd1, 0);
    issue(3'd4, 64'd0, 0);
    issue(3'd3, 64'd2, 0);
    issue(3'd4, 64'd0, 0);
    issue(3'd3, 64'd3, 0);
    // R10 supervisor restore, all pairs in use
    issue(3'd6, img(100, 20, 1'b0, 8'hFF, 8'h3C), 0);
    issue(3'd4, 64'd0, 0);
    // R8 clear selected pairs
    issue(3'd5, 64'hA5, 0);
    issue(3'd6, img(100, 20, 1'b1, 8'hFF, 8'h00), 0);
    // R11/R12 user-state restore dropping pairs
    issue(3'd6, img(128, 127, 1'b0, 8'h0F, 8'hF0), 1);
    // R9 invalid restores
    issue(3'd6, img(128, 127, 1'b0, 8'hFF, 8'h00) | 64'h0002_0000_0000_0000, 0);
    issue(3'd6, img(129, 0, 1'b0, 8'h00, 8'h00), 0);
    issue(3'd6, img(10, 128, 1'b0, 8'h00, 8'h00), 1);
    // R13 idle and reserved opcode
    idle();
    issue(3'd7, 64'hFFFF_FFFF_FFFF_FFFF, 1);
    issue(3'd0, 64'hFF, 0);
    idle();

    for (int i = 0; i < 600; i++) begin
      automatic logic [2:0]  o = 3'($urandom_range(0, 7));
      automatic logic [63:0] d;
      if (o == 3'd6)
        d = img($urandom_range(0, 140), $urandom_range(0, 140), 1'($urandom),
                8'($urandom), 8'($urandom))
            | (($urandom_range(0, 15) == 0) ? 64'h8000_0000_0000_0000 : 64'd0);
      else if (o == 3'd1 || o == 3'd2)
        d = 64'($signed(32'($urandom_range(0, 320)) - 32'sd60));
      else
        d = {$urandom, $urandom};
      if ($urandom_range(0, 5) == 0) idle();
      else issue(o, d, 1'($urandom));
    end
    idle();
    idle();
    @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule